// File: doc/BRIEF.md
# Equivalent-Time Sampling Delay Sequencer

This block runs a sequential equivalent-time acquisition. It takes exactly one sample per qualified trigger. The sampling instant is the trigger plus a programmable delay, and that delay moves forward by one fine step, nominally 5 ps, after each capture. A record of N steps therefore covers N·5 ps of the repetitive input, which gives an equivalent rate of 200 GSa/s.

The sequencer sends a delay code to an external programmable delay element. It waits a programmable settle time, then arms. On the next trigger it pulses a capture strobe for the converter and tags the sample with its step index, so that storage can rebuild the waveform in time order.

The delay element is nonlinear. A correction RAM, loaded from outside with values measured against a known reference signal, maps each step index to the delay code that is actually sent. With correction turned off, the code is the step index itself.

Top module: `ets_delay_sequencer`

## Requirements
- R1: After reset, `delay_code_o`, `strobe_o`, `busy_o` and `done_o` are all 0.
- R2: When idle, a `start_i` pulse latches `rec_last_i` (N-1), `settle_i` and `corr_en_i`. From the following cycle, `busy_o` is 1 and `delay_code_o` holds the code for step 0. While busy, `start_i` is ignored.
- R3: With correction enabled, the code for step k is correction-table entry k. With correction disabled, the code is k zero-extended to `CODE_W` bits.
- R4: After each delay-code update, the block stays unarmed for `settle_i`+1 cycles. Triggers sampled in that window are ignored.
- R5: Once armed, a trigger sampled at a rising edge drives `strobe_o` high for exactly the next cycle. In that cycle `tag_o` equals the current step index.
- R6: A trigger sampled while the strobe is high is ignored. The next step is armed only after the strobe.
- R7: In the cycle after a strobe for step k < N-1, `delay_code_o` holds the code for step k+1, and the settle window restarts.
- R8: In the cycle after the strobe for step N-1, `done_o` is high for one cycle and `busy_o` is 0. Step indices run 0..N-1 in order, and N=1 and N=2^IDX_W both work.
- R9: A correction-table write (`tbl_we_i`, `tbl_addr_i`, `tbl_data_i`) stores one entry per cycle, and that entry is used the next time its step is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a record (honoured only when idle) |
| rec_last_i | input | IDX_W | Record length minus one |
| settle_i | input | SETTLE_W | Settle cycles minus one after each code update |
| corr_en_i | input | 1 | Use the correction table |
| trig_i | input | 1 | Qualified trigger |
| tbl_we_i | input | 1 | Correction table write enable |
| tbl_addr_i | input | IDX_W | Correction table write address |
| tbl_data_i | input | CODE_W | Correction table write data |
| delay_code_o | output | CODE_W | Code for the external delay element |
| strobe_o | output | 1 | Converter capture strobe |
| tag_o | output | IDX_W | Step index of the current sample |
| busy_o | output | 1 | Record in progress |
| done_o | output | 1 | One-cycle pulse after the final capture |

## Verification
The hardest conditions to reach are triggers that must be dropped: those arriving inside the settle window, on the very last settle cycle, and during the strobe itself. The bench holds `trig_i` high through every settle cycle and through each strobe cycle. It then requires a single strobe, issued at the exact cycle the arithmetic predicts. This is swept across record lengths of 1, 5 and the full 16 steps, zero and non-zero settle times, and both correction modes. A restart attempt is also made mid-record.

// File: rtl/ets_pkg.sv
package ets_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_ARMED  = 2'd2,
    ST_STROBE = 2'd3
  } ets_state_e;
endpackage

// File: rtl/ets_corr_table.sv
module ets_corr_table #(
  parameter int IDX_W  = 4,
  parameter int CODE_W = 8
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  waddr_i,
  input  logic [CODE_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  raddr_i,
  output logic [CODE_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << IDX_W;
  logic [CODE_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/ets_settle_timer.sv
module ets_settle_timer #(
  parameter int SETTLE_W = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [SETTLE_W-1:0] len_i,
  output logic                expired_o
);
  logic [SETTLE_W-1:0] cnt_q;
  logic                run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= len_i;
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired_o = run_q && (cnt_q == '0);
endmodule

// File: rtl/ets_step_ctrl.sv
module ets_step_ctrl
  import ets_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int CODE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              trig_i,
  input  logic [IDX_W-1:0]  rec_last_i,
  input  logic              expired_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              load_o,
  output logic [IDX_W-1:0]  idx_nxt_o,
  output logic [CODE_W-1:0] code_o,
  output logic              strobe_o,
  output logic [IDX_W-1:0]  tag_o,
  output logic              busy_o,
  output logic              done_o
);
  ets_state_e       state_q;
  logic [IDX_W-1:0] idx_q, last_q;
  logic [CODE_W-1:0] code_q;
  logic             done_q;
  logic             is_last;

  assign is_last   = (idx_q == last_q);
  assign load_o    = ((state_q == ST_IDLE) && start_i) ||
                     ((state_q == ST_STROBE) && !is_last);
  assign idx_nxt_o = (state_q == ST_IDLE) ? '0 : idx_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      last_q  <= '0;
      code_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load_o) begin
        idx_q  <= idx_nxt_o;
        code_q <= code_i;
      end
      unique case (state_q)
        ST_IDLE:   if (start_i) begin
                     last_q  <= rec_last_i;
                     state_q <= ST_SETTLE;
                   end
        ST_SETTLE: if (expired_i) state_q <= ST_ARMED;
        ST_ARMED:  if (trig_i) state_q <= ST_STROBE;
        ST_STROBE: if (is_last) begin
                     state_q <= ST_IDLE;
                     done_q  <= 1'b1;
                   end else begin
                     state_q <= ST_SETTLE;
                   end
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  assign code_o   = code_q;
  assign strobe_o = (state_q == ST_STROBE);
  assign tag_o    = idx_q;
  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = done_q;
endmodule

// File: rtl/ets_delay_sequencer.sv
module ets_delay_sequencer #(
  parameter int IDX_W    = 4,
  parameter int CODE_W   = 8,
  parameter int SETTLE_W = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [IDX_W-1:0]    rec_last_i,
  input  logic [SETTLE_W-1:0] settle_i,
  input  logic                corr_en_i,
  input  logic                trig_i,
  input  logic                tbl_we_i,
  input  logic [IDX_W-1:0]    tbl_addr_i,
  input  logic [CODE_W-1:0]   tbl_data_i,
  output logic [CODE_W-1:0]   delay_code_o,
  output logic                strobe_o,
  output logic [IDX_W-1:0]    tag_o,
  output logic                busy_o,
  output logic                done_o
);
  logic [SETTLE_W-1:0] settle_q, settle_sel;
  logic                corr_q, corr_sel;
  logic                load, expired;
  logic [IDX_W-1:0]    idx_nxt;
  logic [CODE_W-1:0]   tbl_rd, code_nxt;

  // Configuration is sampled at start and held for the record.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      settle_q <= '0;
      corr_q   <= 1'b0;
    end else if (!busy_o && start_i) begin
      settle_q <= settle_i;
      corr_q   <= corr_en_i;
    end
  end

  assign settle_sel = busy_o ? settle_q : settle_i;
  assign corr_sel   = busy_o ? corr_q   : corr_en_i;

  generate
    if (CODE_W >= IDX_W) begin : g_ext
      assign code_nxt = corr_sel ? tbl_rd : {{(CODE_W-IDX_W){1'b0}}, idx_nxt};
    end else begin : g_trunc
      assign code_nxt = corr_sel ? tbl_rd : idx_nxt[CODE_W-1:0];
    end
  endgenerate

  ets_corr_table #(.IDX_W(IDX_W), .CODE_W(CODE_W)) u_tbl (
    .clk_i   (clk_i),
    .we_i    (tbl_we_i),
    .waddr_i (tbl_addr_i),
    .wdata_i (tbl_data_i),
    .raddr_i (idx_nxt),
    .rdata_o (tbl_rd)
  );

  ets_settle_timer #(.SETTLE_W(SETTLE_W)) u_settle (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .len_i     (settle_sel),
    .expired_o (expired)
  );

  ets_step_ctrl #(.IDX_W(IDX_W), .CODE_W(CODE_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .trig_i     (trig_i),
    .rec_last_i (rec_last_i),
    .expired_i  (expired),
    .code_i     (code_nxt),
    .load_o     (load),
    .idx_nxt_o  (idx_nxt),
    .code_o     (delay_code_o),
    .strobe_o   (strobe_o),
    .tag_o      (tag_o),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );
endmodule

// File: rtl/ets_delay_sequencer_chk.sv
module ets_delay_sequencer_chk #(
  parameter int IDX_W  = 4,
  parameter int CODE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [CODE_W-1:0] delay_code_o,
  input logic              strobe_o,
  input logic [IDX_W-1:0]  tag_o,
  input logic              busy_o,
  input logic              done_o
);
  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |=> !strobe_o); // R5
  AST_STROBE_ONLY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |-> busy_o); // R6
  AST_CODE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !strobe_o) |=> $stable(delay_code_o)); // R4
  AST_DONE_FOLLOWS_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(strobe_o) && !busy_o)); // R8
  AST_TAG_ADVANCES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_o && busy_o) |=> (!busy_o || tag_o == $past(tag_o) + 1'b1)); // R7
  AST_START_IGNORED_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !strobe_o && start_i) |=> busy_o); // R2
endmodule

bind ets_delay_sequencer ets_delay_sequencer_chk #(.IDX_W(IDX_W), .CODE_W(CODE_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .delay_code_o (delay_code_o),
  .strobe_o     (strobe_o),
  .tag_o        (tag_o),
  .busy_o       (busy_o),
  .done_o       (done_o)
);

// File: tb/tb_ets_delay_sequencer.sv
module tb_ets_delay_sequencer;
  localparam int IDX_W = 4, CODE_W = 8, SETTLE_W = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, corr_en = 0, trig = 0, tbl_we = 0;
  logic [IDX_W-1:0]    rec_last = '0, tbl_addr = '0;
  logic [SETTLE_W-1:0] settle = '0;
  logic [CODE_W-1:0]   tbl_data = '0;
  logic [CODE_W-1:0]   code;
  logic                strobe, busy, done;
  logic [IDX_W-1:0]    tag;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  ets_delay_sequencer #(.IDX_W(IDX_W), .CODE_W(CODE_W), .SETTLE_W(SETTLE_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .rec_last_i(rec_last),
    .settle_i(settle), .corr_en_i(corr_en), .trig_i(trig), .tbl_we_i(tbl_we),
    .tbl_addr_i(tbl_addr), .tbl_data_i(tbl_data), .delay_code_o(code),
    .strobe_o(strobe), .tag_o(tag), .busy_o(busy), .done_o(done));

  function automatic logic [CODE_W-1:0] tbl_val(int i, int seed);
    return CODE_W'((i * 37 + 11 + seed) & 8'hff);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_table(int seed);
    for (int i = 0; i < (1 << IDX_W); i++) begin
      @(negedge clk);
      tbl_we = 1; tbl_addr = IDX_W'(i); tbl_data = tbl_val(i, seed);
    end
    @(negedge clk);
    tbl_we = 0;
  endtask

  task automatic run(int n, int s, bit ce, int seed);
    logic [CODE_W-1:0] e;
    @(negedge clk);
    rec_last = IDX_W'(n - 1); settle = SETTLE_W'(s); corr_en = ce; start = 1;
    @(negedge clk);
    start = 0;
    chk("R2 busy", busy, 1);
    for (int k = 0; k < n; k++) begin
      e = ce ? tbl_val(k, seed) : CODE_W'(k);
      // settle window: S+1 cycles, triggers held high and ignored
      for (int c = 0; c <= s; c++) begin
        chk(ce ? "R3 code corr" : "R3 code raw", code, e);
        chk("R4 no strobe in settle", strobe, 0);
        trig = 1;
        start = (k == 1 && c == 0);
        @(negedge clk);
        start = 0;
      end
      trig = 0;
      for (int g = 0; g < (k % 3); g++) begin
        chk("R5 armed idle", strobe, 0);
        @(negedge clk);
      end
      trig = 1;
      @(negedge clk);
      chk("R5 strobe", strobe, 1);
      chk("R5 tag", tag, k);
      chk("R2 code unchanged", code, e);
      @(negedge clk);
      trig = 0;
      chk("R6 single strobe", strobe, 0);
      if (k == n - 1) begin
        chk("R8 done", done, 1);
        chk("R8 idle", busy, 0);
      end else begin
        chk("R7 busy", busy, 1);
        chk("R8 no early done", done, 0);
      end
    end
    @(negedge clk);
    chk("R8 done pulse", done, 0);
  endtask

  initial begin
    #100000000;
    errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 code", code, 0);
    chk("R1 strobe", strobe, 0);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    rst_n = 1;
    load_table(0);
    foreach (int_arr[i]) ;
    for (int ni = 0; ni < 3; ni++)
      for (int si = 0; si < 2; si++)
        for (int ce = 0; ce < 2; ce++)
          run((ni == 0) ? 1 : (ni == 1) ? 5 : 16, si * 3, ce[0], 0);
    // R9 rewrite the table and verify the new entries are used
    load_table(50);
    run(16, 1, 1'b1, 50);
    @(negedge clk);
    trig = 1;
    repeat (3) @(negedge clk);
    chk("R6 idle trigger ignored", strobe, 0);
    trig = 0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  int int_arr[1];
endmodule